// File: doc/BRIEF.md
# Card Host Event Status and Interrupt Unit

This block collects the event pulses raised by the command and data engines of a memory-card host controller and turns them into a single interrupt request. Each one-cycle pulse sets a bit in one of two byte-wide sticky status registers. Software reads these registers and clears bits by writing ones to them. Each status byte has its own mask byte. The interrupt line is raised when the global enable is set and at least one pending bit has its mask bit set.

The same byte-addressed register port also carries the command control byte. That byte holds two self-clearing strobes: command start and response-FIFO reset. It also holds the transfer direction and a 4-bit command-type field, which drive the command engine. A third status byte reports two busy levels and holds one writable clock-control bit. The card-bus engines are not part of the block. They appear only as pulse and level inputs.

The register port is a plain synchronous write port with a combinational read. A write takes effect at the clock edge where `reg_wr` is high. `reg_rdata` always shows the register selected by `reg_addr`. The port has no handshake: every access completes in one cycle.

Top module: `card_evt_irq_unit`

## Requirements
- R1: After reset, every register reads 0 (level bits follow their inputs), `irq_o` is low and all control outputs are low.
- R2: A pulse on `evt0_i[k]` sets bit 4+k of status byte 0 (address 1). A pulse on `evt1_i[k]` sets bit k of status byte 1 (address 2). The bit stays set until it is cleared.
- R3: Writing a status byte clears exactly the bits written as 1 and leaves the other bits unchanged. Writing 0xFF clears every sticky bit of that byte.
- R4: When an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: Bits 1, 2 and 3 of status byte 0 show `wp_i`, `cd_dat3_i` and `cd_pin_i` directly, and clearing writes do not affect them. Bit 0 reads 0.
- R6: Only bits 7:4 of mask byte 0 (address 4) are writable, and its low bits read 0. Only bits 7:1 of mask byte 1 (address 5) are writable, and its bit 0 reads 0.
- R7: `irq_o` is a register. It goes high one cycle after the global enable is set and some status bit has a set mask bit.
- R8: `irq_o` falls in the cycle after the last masked pending bit is cleared, or the cycle after the global enable is cleared.
- R9: The global interrupt enable is bit 7 of address 6. The other bits of that byte read 0.
- R10: Control byte (address 0) bit 0 (command start) and bit 3 (FIFO reset) drive `cmd_start_o` and `fifo_rst_o` for exactly the one cycle after the write. After that they read 0.
- R11: Control bit 2 (`cmd_wr_o`) and bits 7:4 (`cmd_type_o`) hold the value last written. Control bit 1 reads 0.
- R12: Address 3 reads `cmd_busy_i` at bit 4 and `dat_busy_i` at bit 5. Bit 7 is a read/write bit that drives `force_clk_dis_o`. Its other bits read 0.
- R13: Address 7 reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| evt0_i | input | 4 | Event pulses for status byte 0 bits 7:4 |
| evt1_i | input | 8 | Event pulses for status byte 1 |
| wp_i | input | 1 | Write-protect level |
| cd_dat3_i | input | 1 | Card detect level seen on data line 3 |
| cd_pin_i | input | 1 | Card detect level from the detect pin |
| cmd_busy_i | input | 1 | Command/response busy level |
| dat_busy_i | input | 1 | Data-response busy level |
| irq_o | output | 1 | Registered interrupt request |
| cmd_start_o | output | 1 | One-cycle command start strobe |
| fifo_rst_o | output | 1 | One-cycle response FIFO reset strobe |
| cmd_wr_o | output | 1 | Transfer direction (1 = write) |
| cmd_type_o | output | 4 | Command type field |
| force_clk_dis_o | output | 1 | Forced-clock disable bit |

## Verification
The hardest case to reach from the ports is an event pulse and a write-one-to-clear landing on the same bit in the same cycle. Close behind it is the one-cycle lag of the interrupt behind the last clear. Random stimulus makes events sparse and writes frequent, so clears often meet live pending bits and coincidences do occur. Directed steps then force the exact collision and the exact clear-then-deassert sequence. After every cycle the bench checks the outputs and reads back all eight addresses against its own model.

// File: rtl/card_evt_irq_pkg.sv
package card_evt_irq_pkg;
  localparam int REG_W   = 8;
  localparam int ADDR_W  = 3;
  localparam int CTYPE_W = 4;
  localparam int NBANK   = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_STS0 = 3'd1,
    A_STS1 = 3'd2,
    A_STS2 = 3'd3,
    A_MSK0 = 3'd4,
    A_MSK1 = 3'd5,
    A_GIE  = 3'd6,
    A_NONE = 3'd7
  } reg_addr_e;

  localparam logic [REG_W-1:0] STICKY0 = 8'hF0;
  localparam logic [REG_W-1:0] STICKY1 = 8'hFF;
  localparam logic [REG_W-1:0] MSK0_RW = 8'hF0;
  localparam logic [REG_W-1:0] MSK1_RW = 8'hFE;

  localparam int CTL_START = 0;
  localparam int CTL_DIR   = 2;
  localparam int CTL_FRST  = 3;
  localparam int CTL_TYPE  = 4;
  localparam int GIE_BIT   = 7;
  localparam int S0_WP     = 1;
  localparam int S0_DAT3   = 2;
  localparam int S0_PIN    = 3;
  localparam int S2_CBUSY  = 4;
  localparam int S2_DBUSY  = 5;
  localparam int S2_FCLK   = 7;
endpackage

// File: rtl/evt_sticky_bank.sv
module evt_sticky_bank #(
  parameter int              W      = 8,
  parameter logic [W-1:0]    STICKY = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] sts_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (STICKY[i]) begin : g_flop
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= (q & ~(clr_en_i & clr_i[i])) | evt_i[i];
      end
      assign sts_o[i] = q;
    end else begin : g_zero
      assign sts_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/host_ctrl_regs.sv
module host_ctrl_regs
  import card_evt_irq_pkg::*;
#(
  parameter int W = REG_W,
  parameter int TW = CTYPE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_ctrl_i,
  input  logic         wr_msk0_i,
  input  logic         wr_msk1_i,
  input  logic         wr_gie_i,
  input  logic         wr_sts2_i,
  input  logic [W-1:0] wdata_i,
  output logic         start_o,
  output logic         frst_o,
  output logic         dir_o,
  output logic [TW-1:0] ctype_o,
  output logic [W-1:0] msk0_o,
  output logic [W-1:0] msk1_o,
  output logic         gie_o,
  output logic         fclk_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_o <= 1'b0;
      frst_o  <= 1'b0;
      dir_o   <= 1'b0;
      ctype_o <= '0;
    end else if (wr_ctrl_i) begin
      start_o <= wdata_i[CTL_START];
      frst_o  <= wdata_i[CTL_FRST];
      dir_o   <= wdata_i[CTL_DIR];
      ctype_o <= wdata_i[CTL_TYPE +: TW];
    end else begin
      start_o <= 1'b0;
      frst_o  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msk0_o <= '0;
      msk1_o <= '0;
      gie_o  <= 1'b0;
      fclk_o <= 1'b0;
    end else begin
      if (wr_msk0_i) msk0_o <= wdata_i & MSK0_RW;
      if (wr_msk1_i) msk1_o <= wdata_i & MSK1_RW;
      if (wr_gie_i)  gie_o  <= wdata_i[GIE_BIT];
      if (wr_sts2_i) fclk_o <= wdata_i[S2_FCLK];
    end
  end
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int NB = 2,
  parameter int W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NB-1:0][W-1:0] sts_i,
  input  logic [NB-1:0][W-1:0] msk_i,
  input  logic                 gie_i,
  output logic                 irq_o
);
  logic [NB-1:0] hit;
  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign hit[b] = |(sts_i[b] & msk_i[b]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= gie_i & (|hit);
  end
endmodule

// File: rtl/card_evt_irq_unit.sv
module card_evt_irq_unit
  import card_evt_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic [3:0]         evt0_i,
  input  logic [REG_W-1:0]   evt1_i,
  input  logic               wp_i,
  input  logic               cd_dat3_i,
  input  logic               cd_pin_i,
  input  logic               cmd_busy_i,
  input  logic               dat_busy_i,
  output logic               irq_o,
  output logic               cmd_start_o,
  output logic               fifo_rst_o,
  output logic               cmd_wr_o,
  output logic [CTYPE_W-1:0] cmd_type_o,
  output logic               force_clk_dis_o
);
  localparam logic [NBANK-1:0][REG_W-1:0] STICKY_SET = {STICKY1, STICKY0};
  localparam logic [NBANK-1:0][ADDR_W-1:0] BANK_ADDR = {A_STS1, A_STS0};

  reg_addr_e sel;
  assign sel = reg_addr_e'(reg_addr);

  logic [NBANK-1:0][REG_W-1:0] evt_vec;
  logic [NBANK-1:0][REG_W-1:0] sts_q;
  logic [NBANK-1:0][REG_W-1:0] msk_q;
  logic gie_q;

  assign evt_vec[0] = {evt0_i, 4'b0000};
  assign evt_vec[1] = evt1_i;

  for (genvar b = 0; b < NBANK; b++) begin : g_sts
    evt_sticky_bank #(.W(REG_W), .STICKY(STICKY_SET[b])) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (evt_vec[b]),
      .clr_en_i (reg_wr && (reg_addr == BANK_ADDR[b])),
      .clr_i    (reg_wdata),
      .sts_o    (sts_q[b])
    );
  end

  host_ctrl_regs u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl_i (reg_wr && sel == A_CTRL),
    .wr_msk0_i (reg_wr && sel == A_MSK0),
    .wr_msk1_i (reg_wr && sel == A_MSK1),
    .wr_gie_i  (reg_wr && sel == A_GIE),
    .wr_sts2_i (reg_wr && sel == A_STS2),
    .wdata_i   (reg_wdata),
    .start_o   (cmd_start_o),
    .frst_o    (fifo_rst_o),
    .dir_o     (cmd_wr_o),
    .ctype_o   (cmd_type_o),
    .msk0_o    (msk_q[0]),
    .msk1_o    (msk_q[1]),
    .gie_o     (gie_q),
    .fclk_o    (force_clk_dis_o)
  );

  irq_merge #(.NB(NBANK), .W(REG_W)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .sts_i (sts_q),
    .msk_i (msk_q),
    .gie_i (gie_q),
    .irq_o (irq_o)
  );

  logic [REG_W-1:0] ctrl_view, lvl0_view, sts2_view, gie_view;
  always_comb begin
    ctrl_view = '0;
    ctrl_view[CTL_START] = cmd_start_o;
    ctrl_view[CTL_DIR]   = cmd_wr_o;
    ctrl_view[CTL_FRST]  = fifo_rst_o;
    ctrl_view[CTL_TYPE +: CTYPE_W] = cmd_type_o;
    lvl0_view = '0;
    lvl0_view[S0_WP]   = wp_i;
    lvl0_view[S0_DAT3] = cd_dat3_i;
    lvl0_view[S0_PIN]  = cd_pin_i;
    sts2_view = '0;
    sts2_view[S2_CBUSY] = cmd_busy_i;
    sts2_view[S2_DBUSY] = dat_busy_i;
    sts2_view[S2_FCLK]  = force_clk_dis_o;
    gie_view = '0;
    gie_view[GIE_BIT] = gie_q;
  end

  always_comb begin
    case (sel)
      A_CTRL:  reg_rdata = ctrl_view;
      A_STS0:  reg_rdata = sts_q[0] | lvl0_view;
      A_STS1:  reg_rdata = sts_q[1];
      A_STS2:  reg_rdata = sts2_view;
      A_MSK0:  reg_rdata = msk_q[0];
      A_MSK1:  reg_rdata = msk_q[1];
      A_GIE:   reg_rdata = gie_view;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/card_evt_irq_checker.sv
module card_evt_irq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] reg_addr,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic [7:0] evt1_i,
  input logic [7:0] sts1,
  input logic       gie_q,
  input logic       irq_o,
  input logic       cmd_start_o,
  input logic       wp_i,
  input logic       cd_dat3_i,
  input logic       cd_pin_i
);
  // R2 and R4: a pulse always leaves its bit set, even beside a clear
  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt1_i) |=> ((sts1 & $past(evt1_i)) == $past(evt1_i)));

  assert_hold_without_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 3'd2) |=> ((sts1 & $past(sts1)) == $past(sts1)));

  assert_level_view_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd1) |-> (reg_rdata[3:1] == {cd_pin_i, cd_dat3_i, wp_i} && !reg_rdata[0]));

  assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(gie_q));

  assert_irq_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |=> !irq_o);

  assert_start_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start_o && !(reg_wr && reg_addr == 3'd0 && reg_wdata[0])) |=> !cmd_start_o);
endmodule

bind card_evt_irq_unit card_evt_irq_checker i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_addr    (reg_addr),
  .reg_wr      (reg_wr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .evt1_i      (evt1_i),
  .sts1        (sts_q[1]),
  .gie_q       (gie_q),
  .irq_o       (irq_o),
  .cmd_start_o (cmd_start_o),
  .wp_i        (wp_i),
  .cd_dat3_i   (cd_dat3_i),
  .cd_pin_i    (cd_pin_i)
);

// File: tb/test_card_evt_irq_unit.sv
`timescale 1ns/10ps
module test_card_evt_irq_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [3:0] evt0_i = '0;
  logic [7:0] evt1_i = '0;
  logic wp_i = 0, cd_dat3_i = 0, cd_pin_i = 0, cmd_busy_i = 0, dat_busy_i = 0;
  logic irq_o, cmd_start_o, fifo_rst_o, cmd_wr_o, force_clk_dis_o;
  logic [3:0] cmd_type_o;

  card_evt_irq_unit i_card_evt_irq_unit (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt0_i(evt0_i),
    .evt1_i(evt1_i), .wp_i(wp_i), .cd_dat3_i(cd_dat3_i), .cd_pin_i(cd_pin_i),
    .cmd_busy_i(cmd_busy_i), .dat_busy_i(dat_busy_i), .irq_o(irq_o),
    .cmd_start_o(cmd_start_o), .fifo_rst_o(fifo_rst_o), .cmd_wr_o(cmd_wr_o),
    .cmd_type_o(cmd_type_o), .force_clk_dis_o(force_clk_dis_o)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // bench model of the programmer-visible state
  logic [3:0] m_s0 = '0;
  logic [7:0] m_s1 = '0, m_m1 = '0;
  logic [3:0] m_m0 = '0, m_type = '0;
  logic m_gie = 0, m_dir = 0, m_start = 0, m_frst = 0, m_fclk = 0, m_irq = 0;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input int k);
    case (k)
      0: return {m_type, m_frst, m_dir, 1'b0, m_start};
      1: return {m_s0, cd_pin_i, cd_dat3_i, wp_i, 1'b0};
      2: return m_s1;
      3: return {m_fclk, 1'b0, dat_busy_i, cmd_busy_i, 4'b0};
      4: return {m_m0, 4'b0};
      5: return m_m1;
      6: return {m_gie, 7'b0};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input int k);
    case (k)
      0: return "R10/R11 ctrl";
      1: return "R2/R5 status0";
      2: return "R2/R3 status1";
      3: return "R12 status2";
      4: return "R6 mask0";
      5: return "R6 mask1";
      6: return "R9 enable";
      default: return "R13 unused addr";
    endcase
  endfunction

  task automatic sweep();
    for (int k = 0; k < 8; k++) begin
      reg_addr = 3'(k);
      #0.1;
      chk(tag_of(k), reg_rdata, exp_rd(k));
    end
  endtask

  task automatic run_cycle(input logic [3:0] e0, input logic [7:0] e1, input logic wr,
                           input logic [2:0] a, input logic [7:0] d, input logic [4:0] lv);
    logic irq_next;
    @(negedge clk);
    evt0_i = e0; evt1_i = e1; reg_wr = wr; reg_addr = a; reg_wdata = d;
    {dat_busy_i, cmd_busy_i, cd_pin_i, cd_dat3_i, wp_i} = lv;
    irq_next = m_gie & ((|(m_s0 & m_m0)) | (|(m_s1 & m_m1)));
    @(posedge clk);
    #1;
    reg_wr = 0; evt0_i = '0; evt1_i = '0;
    if (wr && a == 3'd1) m_s0 = m_s0 & ~d[7:4];
    m_s0 = m_s0 | e0;
    if (wr && a == 3'd2) m_s1 = m_s1 & ~d;
    m_s1 = m_s1 | e1;
    if (wr && a == 3'd0) begin
      m_start = d[0]; m_frst = d[3]; m_dir = d[2]; m_type = d[7:4];
    end else begin
      m_start = 0; m_frst = 0;
    end
    if (wr && a == 3'd3) m_fclk = d[7];
    if (wr && a == 3'd4) m_m0 = d[7:4];
    if (wr && a == 3'd5) m_m1 = d & 8'hFE;
    if (wr && a == 3'd6) m_gie = d[7];
    m_irq = irq_next;
    chk("R7/R8 irq", {7'b0, irq_o}, {7'b0, m_irq});
    chk("R10 start strobe", {7'b0, cmd_start_o}, {7'b0, m_start});
    chk("R10 fifo strobe", {7'b0, fifo_rst_o}, {7'b0, m_frst});
    chk("R11 dir/type", {3'b0, cmd_wr_o, cmd_type_o}, {3'b0, m_dir, m_type});
    chk("R12 clock bit", {7'b0, force_clk_dis_o}, {7'b0, m_fclk});
    sweep();
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 irq at reset", {7'b0, irq_o}, 8'h00);
    chk("R1 strobes at reset", {6'b0, cmd_start_o, fifo_rst_o}, 8'h00);
    sweep();
    @(negedge clk);
    rst_n = 1;

    // R10/R11: control write with both strobes
    run_cycle(4'h0, 8'h00, 1, 3'd0, 8'hAD, 5'b0);
    chk("R10 start right after write", {7'b0, cmd_start_o}, 8'h01);
    run_cycle(4'h0, 8'h00, 0, 3'd0, 8'h00, 5'b0);
    chk("R10 start gone", {7'b0, cmd_start_o}, 8'h00);
    chk("R11 type held", {4'b0, cmd_type_o}, 8'h0A);

    // R7/R8: mask, enable, event, clear, deassert
    run_cycle(4'h0, 8'h00, 1, 3'd5, 8'h03, 5'b0);
    run_cycle(4'h0, 8'h00, 1, 3'd6, 8'hFF, 5'b0);
    run_cycle(4'h0, 8'h02, 0, 3'd0, 8'h00, 5'b0);
    chk("R7 not yet high", {7'b0, irq_o}, 8'h00);
    run_cycle(4'h0, 8'h00, 0, 3'd0, 8'h00, 5'b0);
    chk("R7 irq raised", {7'b0, irq_o}, 8'h01);
    run_cycle(4'h0, 8'h00, 1, 3'd2, 8'h02, 5'b0);
    chk("R8 still high in clear cycle", {7'b0, irq_o}, 8'h01);
    run_cycle(4'h0, 8'h00, 0, 3'd0, 8'h00, 5'b0);
    chk("R8 irq dropped", {7'b0, irq_o}, 8'h00);

    // R4: event and clear on the same bit in one cycle
    run_cycle(4'h0, 8'h10, 0, 3'd0, 8'h00, 5'b0);
    run_cycle(4'h0, 8'h10, 1, 3'd2, 8'hFF, 5'b0);
    reg_addr = 3'd2; #0.1;
    chk("R4 event wins over clear", reg_rdata, 8'h10);
    run_cycle(4'h8, 8'h00, 1, 3'd1, 8'hF0, 5'b0);
    reg_addr = 3'd1; #0.1;
    chk("R4 status0 event wins", reg_rdata, 8'h80);

    // R3: full clear; R5: level bits ignore clears
    run_cycle(4'h0, 8'h00, 1, 3'd1, 8'hFF, 5'b00111);
    reg_addr = 3'd1; #0.1;
    chk("R3/R5 clear all keeps levels", reg_rdata, 8'h0E);
    run_cycle(4'h0, 8'h00, 1, 3'd2, 8'hFF, 5'b0);
    reg_addr = 3'd2; #0.1;
    chk("R3 status1 cleared", reg_rdata, 8'h00);

    // R13: writes to the unused address change nothing
    run_cycle(4'h0, 8'h00, 1, 3'd7, 8'hFF, 5'b11000);
    chk("R13 outputs unchanged", {7'b0, force_clk_dis_o}, {7'b0, m_fclk});

    // random phase: sparse events, frequent writes
    for (int i = 0; i < 600; i++) begin
      logic [3:0] e0;
      logic [7:0] e1;
      e0 = 4'($urandom & $urandom & $urandom);
      e1 = 8'($urandom & $urandom & $urandom);
      run_cycle(e0, e1, 1'($urandom), 3'($urandom), 8'($urandom), 5'($urandom));
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule